// File: doc/BRIEF.md
# Masked Vector Compare and Subtract Unit

This block holds a slice of a vector register file (several registers of 64 elements each) together with a length register and a 64-bit per-element mask. It runs two kinds of vector operation. The first is a compare-not-equal of a vector against a scalar, which produces a mask. The second is an element-wise subtract of two vectors, which the mask gates. The length register caps how many leading elements an operation visits. Work is spread over four parallel lanes. Lane k takes elements k, k+4, k+8 and so on, so one group of four elements is retired per clock.

A controller issues one command at a time on the command port. The command carries an opcode, a length value, a scalar and three register indices. The controller then waits for the one-cycle done pulse. While the block is idle, registers are loaded element by element through a write port. A combinational read port returns any element at any time. The length register and the mask are visible as outputs.

Top module: `mvu_top`

## Requirements
- R1: After reset the length register reads 64, every mask bit reads 1, and busy and done are both low.
- R2: Opcode 1 (set length) loads the length register with the command's length value. A value above 64 is stored as 64. Done pulses in the cycle after the accept edge.
- R3: Opcode 2 (compare) sets mask bit i to 1 when element i of the first source register differs from the scalar, and to 0 when they are equal, for every i below the length. Mask bits at the length and above keep their value.
- R4: Opcode 3 (subtract) writes (first source minus second source) modulo 2^16 into element i of the destination register only where i is below the length and mask bit i is 1. All other elements keep their value.
- R5: A compare or subtract with length L>0 holds busy high for ceil(L/4) cycles, one element group per cycle. Done pulses in the cycle that follows, which is ceil(L/4)+1 cycles after the accept edge.
- R6: A compare or subtract issued with length 0 raises done one cycle after the accept edge, never raises busy, and changes neither the registers nor the mask.
- R7: When the length is not a multiple of 4, the lanes whose element index in the last group is at or above the length write nothing.
- R8: A command or a write-port request presented while busy is high is ignored. The length register, the mask and the registers are left untouched by it.
- R9: Opcode 4 (mask reset) sets all 64 mask bits to 1, with done one cycle after the accept edge. Opcode 0 and the unused codes only pulse done.
- R10: Busy and done are never high together. Done pulses exactly once per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present; accepted when busy_o is low |
| cmd_op_i | input | 3 | Opcode: 0 none, 1 set length, 2 compare, 3 subtract, 4 mask reset |
| cmd_vl_i | input | 7 | Length value for set length |
| cmd_scalar_i | input | 16 | Scalar for compare |
| cmd_vd_i | input | 2 | Destination register index |
| cmd_vs1_i | input | 2 | First source register index |
| cmd_vs2_i | input | 2 | Second source register index |
| wr_en_i | input | 1 | Element write request, honoured only when idle |
| wr_reg_i | input | 2 | Register index for element write |
| wr_idx_i | input | 6 | Element index for element write |
| wr_data_i | input | 16 | Element write data |
| rd_reg_i | input | 2 | Register index for element read |
| rd_idx_i | input | 6 | Element index for element read |
| rd_data_o | output | 16 | Element read data, combinational |
| vl_o | output | 7 | Current length register |
| mask_o | output | 64 | Current mask, bit i for element i |
| busy_o | output | 1 | Vector operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Set length, mask reset, the no-op codes and any length-0 vector operation are due one cycle after the accept edge. A compare or subtract of length L is due ceil(L/4)+1 cycles after it. Each issued command's due latency goes into a queue. A monitor compares, on the falling clock edge, the cycle count between issue and the observed done pulse against that latency, and flags any done with nothing queued. Register contents, the mask and the length are compared with a bench-side model once busy has dropped, through the read port and outputs, so that no sample straddles a state change.

// File: rtl/mvu_pkg.sv
package mvu_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_SETVL   = 3'd1,
    OP_CMPNE   = 3'd2,
    OP_VSUB    = 3'd3,
    OP_MASKSET = 3'd4
  } op_e;
endpackage

// File: rtl/mvu_seq.sv
// Group sequencer: one element group per cycle, done one cycle after the last.
module mvu_seq #(
  parameter int VL_W  = 7,
  parameter int GRP_W = 4,
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vec_start_i,
  input  logic             instant_i,
  input  logic [VL_W-1:0]  vl_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [GRP_W-1:0] grp_o
);
  localparam int LSH = $clog2(LANES);

  logic [VL_W:0]    ngrp;
  logic [GRP_W-1:0] last_d, last_q;
  logic             vl_zero;

  assign vl_zero = (vl_i == '0);
  assign ngrp    = ((VL_W+1)'(vl_i) + (VL_W+1)'(LANES - 1)) >> LSH;
  assign last_d  = GRP_W'(ngrp) - GRP_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      grp_o  <= '0;
      last_q <= '0;
    end else begin
      done_o <= 1'b0;
      if (vec_start_i && !vl_zero) begin
        busy_o <= 1'b1;
        grp_o  <= '0;
        last_q <= last_d;
      end else if (vec_start_i || instant_i) begin
        done_o <= 1'b1;
      end else if (busy_o) begin
        if (grp_o == last_q) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          grp_o <= grp_o + GRP_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mvu_lane.sv
// One lane: element index grp*LANES+LANE, compare and subtract datapath.
module mvu_lane
  import mvu_pkg::*;
#(
  parameter int ELEM_W = 16,
  parameter int VL_W   = 7,
  parameter int IDX_W  = 6,
  parameter int GRP_W  = 4,
  parameter int LANES  = 4,
  parameter int LANE   = 0
) (
  input  logic              active_i,
  input  op_e               op_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [ELEM_W-1:0] a_i,
  input  logic [ELEM_W-1:0] b_i,
  input  logic [ELEM_W-1:0] scalar_i,
  input  logic              mask_bit_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              wr_en_o,
  output logic [ELEM_W-1:0] wr_val_o,
  output logic              mask_we_o,
  output logic              mask_val_o
);
  logic [VL_W-1:0] idx_ext;
  logic            in_range;

  assign idx_ext    = VL_W'(grp_i) * VL_W'(LANES) + VL_W'(LANE);
  assign idx_o      = idx_ext[IDX_W-1:0];
  assign in_range   = active_i && (idx_ext < vl_i);
  assign wr_val_o   = a_i - b_i;
  assign wr_en_o    = in_range && (op_i == OP_VSUB) && mask_bit_i;
  assign mask_val_o = (a_i != scalar_i);
  assign mask_we_o  = in_range && (op_i == OP_CMPNE);
endmodule

// File: rtl/mvu_top.sv
module mvu_top
  import mvu_pkg::*;
#(
  parameter int ELEM_W    = 16,
  parameter int MAX_VL    = 64,
  parameter int LANES     = 4,
  parameter int NUM_VREGS = 4,
  localparam int VL_W     = $clog2(MAX_VL + 1),
  localparam int IDX_W    = $clog2(MAX_VL),
  localparam int RID_W    = $clog2(NUM_VREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [VL_W-1:0]   cmd_vl_i,
  input  logic [ELEM_W-1:0] cmd_scalar_i,
  input  logic [RID_W-1:0]  cmd_vd_i,
  input  logic [RID_W-1:0]  cmd_vs1_i,
  input  logic [RID_W-1:0]  cmd_vs2_i,
  input  logic              wr_en_i,
  input  logic [RID_W-1:0]  wr_reg_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ELEM_W-1:0] wr_data_i,
  input  logic [RID_W-1:0]  rd_reg_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ELEM_W-1:0] rd_data_o,
  output logic [VL_W-1:0]   vl_o,
  output logic [MAX_VL-1:0] mask_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int GRPS  = MAX_VL / LANES;
  localparam int GRP_W = (GRPS > 1) ? $clog2(GRPS) : 1;

  logic [ELEM_W-1:0] vrf [NUM_VREGS][MAX_VL];
  logic [MAX_VL-1:0] mask_q;
  logic [VL_W-1:0]   vl_q;

  op_e               op_in, op_q;
  logic [RID_W-1:0]  vd_q, vs1_q, vs2_q;
  logic [ELEM_W-1:0] scalar_q;

  logic              accept, vec_start, instant;
  logic [GRP_W-1:0]  grp;

  logic [IDX_W-1:0]  lane_idx   [LANES];
  logic              lane_we    [LANES];
  logic [ELEM_W-1:0] lane_val   [LANES];
  logic              lane_mwe   [LANES];
  logic              lane_mval  [LANES];

  assign op_in     = op_e'(cmd_op_i);
  assign accept    = cmd_valid_i && !busy_o;
  assign vec_start = accept && (op_in == OP_CMPNE || op_in == OP_VSUB);
  assign instant   = accept && !vec_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q     <= VL_W'(MAX_VL);
      op_q     <= OP_NOP;
      vd_q     <= '0;
      vs1_q    <= '0;
      vs2_q    <= '0;
      scalar_q <= '0;
    end else if (accept) begin
      op_q     <= op_in;
      vd_q     <= cmd_vd_i;
      vs1_q    <= cmd_vs1_i;
      vs2_q    <= cmd_vs2_i;
      scalar_q <= cmd_scalar_i;
      if (op_in == OP_SETVL)
        vl_q <= (cmd_vl_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : cmd_vl_i;
    end
  end

  mvu_seq #(
    .VL_W (VL_W),
    .GRP_W(GRP_W),
    .LANES(LANES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vec_start_i(vec_start),
    .instant_i  (instant),
    .vl_i       (vl_q),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .grp_o      (grp)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    mvu_lane #(
      .ELEM_W(ELEM_W),
      .VL_W  (VL_W),
      .IDX_W (IDX_W),
      .GRP_W (GRP_W),
      .LANES (LANES),
      .LANE  (k)
    ) u_lane (
      .active_i  (busy_o),
      .op_i      (op_q),
      .grp_i     (grp),
      .vl_i      (vl_q),
      .a_i       (vrf[vs1_q][lane_idx[k]]),
      .b_i       (vrf[vs2_q][lane_idx[k]]),
      .scalar_i  (scalar_q),
      .mask_bit_i(mask_q[lane_idx[k]]),
      .idx_o     (lane_idx[k]),
      .wr_en_o   (lane_we[k]),
      .wr_val_o  (lane_val[k]),
      .mask_we_o (lane_mwe[k]),
      .mask_val_o(lane_mval[k])
    );
  end

  // Register file has no reset; contents are loaded through the write port.
  always_ff @(posedge clk_i) begin
    if (wr_en_i && !busy_o)
      vrf[wr_reg_i][wr_idx_i] <= wr_data_i;
    for (int k = 0; k < LANES; k++)
      if (lane_we[k])
        vrf[vd_q][lane_idx[k]] <= lane_val[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (instant && op_in == OP_MASKSET) begin
      mask_q <= '1;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (lane_mwe[k])
          mask_q[lane_idx[k]] <= lane_mval[k];
    end
  end

  assign rd_data_o = vrf[rd_reg_i][rd_idx_i];
  assign vl_o      = vl_q;
  assign mask_o    = mask_q;
endmodule

// File: rtl/mvu_chk.sv
module mvu_chk
  import mvu_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int LANES  = 4,
  parameter int VL_W   = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_op_i,
  input logic [VL_W-1:0]   vl_o,
  input logic [MAX_VL-1:0] mask_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam int GRPS = MAX_VL / LANES;

  logic [VL_W-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + VL_W'(1);
    else             busy_cnt <= '0;
  end

  assert_vl_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_o <= VL_W'(MAX_VL));

  assert_busy_span_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= VL_W'(GRPS));

  assert_fall_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_rise_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i));

  assert_mask_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(cmd_valid_i && cmd_op_i == 3'(OP_MASKSET))) |=> $stable(mask_o));

  assert_vl_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(vl_o));

  assert_busy_done_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_done_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(cmd_valid_i && !busy_o) || $past(busy_o)));
endmodule

bind mvu_top mvu_chk #(
  .MAX_VL(MAX_VL),
  .LANES (LANES),
  .VL_W  (VL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .vl_o       (vl_o),
  .mask_o     (mask_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/mvu_top_tb_top.sv
`timescale 1ns/1ps
module mvu_top_tb_top;
  import mvu_pkg::*;

  localparam int NREG = 4;
  localparam int NEL  = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [2:0]  cmd_op_i = '0;
  logic [6:0]  cmd_vl_i = '0;
  logic [15:0] cmd_scalar_i = '0;
  logic [1:0]  cmd_vd_i = '0, cmd_vs1_i = '0, cmd_vs2_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_reg_i = '0;
  logic [5:0]  wr_idx_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  rd_reg_i = '0;
  logic [5:0]  rd_idx_i = '0;
  logic [15:0] rd_data_o;
  logic [6:0]  vl_o;
  logic [63:0] mask_o;
  logic        busy_o, done_o;

  always #5 clk_i = ~clk_i;

  mvu_top dut_i (.*);

  typedef struct {int issue; int lat; string req;} exp_t;
  exp_t exp_q[$];

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  logic [15:0] m_vrf [NREG][NEL];
  logic [63:0] m_mask;
  int          m_vl;

  always @(posedge clk_i) cyc <= cyc + 1;

  // Monitor: each done pulse must match the oldest queued command's latency.
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10: done with no command pending, actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (cyc - e.issue != e.lat) begin
          errors++;
          $display("FAIL %s: done latency actual=%0d expected=%0d", e.req, cyc - e.issue, e.lat);
        end
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_elem(input int r, input int i, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_reg_i = 2'(r); wr_idx_i = 6'(i); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    m_vrf[r][i] = d;
  endtask

  function automatic int groups(input int vl);
    return (vl + 3) / 4;
  endfunction

  // Issue a command; returns at the falling edge after the accept edge.
  task automatic send(input op_e op, input int vl, input logic [15:0] sc,
                      input int vd, input int vs1, input int vs2, input string req);
    int lat;
    lat = 1;
    if ((op == OP_CMPNE || op == OP_VSUB) && m_vl > 0) lat = groups(m_vl) + 1;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = 3'(op); cmd_vl_i = 7'(vl); cmd_scalar_i = sc;
    cmd_vd_i = 2'(vd); cmd_vs1_i = 2'(vs1); cmd_vs2_i = 2'(vs2);
    exp_q.push_back('{issue: cyc, lat: lat, req: req});
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    // bench model
    case (op)
      OP_SETVL:   m_vl = (vl > 64) ? 64 : vl;
      OP_MASKSET: m_mask = '1;
      OP_CMPNE:   for (int i = 0; i < m_vl; i++) m_mask[i] = (m_vrf[vs1][i] != sc);
      OP_VSUB:    for (int i = 0; i < m_vl; i++)
                    if (m_mask[i]) m_vrf[vd][i] = m_vrf[vs1][i] - m_vrf[vs2][i];
      default: ;
    endcase
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check_regs(input string req);
    int bad;
    bad = 0;
    for (int r = 0; r < NREG; r++)
      for (int i = 0; i < NEL; i++) begin
        rd_reg_i = 2'(r); rd_idx_i = 6'(i);
        #1;
        if (rd_data_o !== m_vrf[r][i]) begin
          if (bad == 0)
            $display("FAIL %s: reg %0d elem %0d actual=%h expected=%h",
                     req, r, i, rd_data_o, m_vrf[r][i]);
          bad++;
        end
      end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    m_mask = '1;
    m_vl = 64;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 vl", 64'(vl_o), 64'd64);
    check("R1 mask", mask_o, '1);
    check("R1 busy/done", {62'd0, busy_o, done_o}, 64'd0);

    for (int r = 0; r < NREG; r++)
      for (int i = 0; i < NEL; i++)
        wr_elem(r, i, (r == 0) ? ((i % 3 == 0) ? 16'h0055 : 16'(i * 257 + 3))
                               : 16'(r * 16'h1111 + i * 7));
    check_regs("R8 idle write");

    // R4 R5: full-length subtract under the all-ones mask
    send(OP_VSUB, 0, 16'h0, 2, 0, 1, "R5");
    check("R5 busy after accept", 64'(busy_o), 64'd1);
    wait_idle();
    check_regs("R4 full subtract");

    // R2: set length
    send(OP_SETVL, 10, 16'h0, 0, 0, 0, "R2");
    check("R2 vl=10", 64'(vl_o), 64'd10);

    // R3: compare with length 10, upper mask bits stay 1
    send(OP_CMPNE, 0, 16'h0055, 0, 0, 0, "R3");
    wait_idle();
    check("R3 mask len10", mask_o, m_mask);

    // R4 R7: masked subtract, partial final group
    send(OP_VSUB, 0, 16'h0, 3, 0, 1, "R7");
    wait_idle();
    check_regs("R7 partial group masked subtract");

    // R2: clamp
    send(OP_SETVL, 100, 16'h0, 0, 0, 0, "R2");
    check("R2 clamp", 64'(vl_o), 64'd64);

    // R3: full compare against a different scalar
    send(OP_CMPNE, 0, 16'h2225, 0, 2, 0, "R3");
    wait_idle();
    check("R3 mask full", mask_o, m_mask);

    // R4: subtract with the fresh mask
    send(OP_VSUB, 0, 16'h0, 1, 3, 2, "R4");
    wait_idle();
    check_regs("R4 masked full subtract");

    // R9: mask reset and no-op
    send(OP_MASKSET, 0, 16'h0, 0, 0, 0, "R9");
    check("R9 mask all ones", mask_o, '1);
    send(OP_NOP, 5, 16'h0, 0, 0, 0, "R9");
    check("R9 nop keeps vl", 64'(vl_o), 64'd64);

    // R6: zero length
    send(OP_SETVL, 0, 16'h0, 0, 0, 0, "R2");
    send(OP_VSUB, 0, 16'h0, 0, 1, 2, "R6");
    check("R6 no busy", 64'(busy_o), 64'd0);
    send(OP_CMPNE, 0, 16'hFFFF, 0, 1, 0, "R6");
    check("R6 mask unchanged", mask_o, '1);
    check_regs("R6 no writes");

    // R8: command and element write while busy are dropped
    send(OP_SETVL, 64, 16'h0, 0, 0, 0, "R2");
    send(OP_VSUB, 0, 16'h0, 0, 1, 2, "R8");
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = 3'(OP_SETVL); cmd_vl_i = 7'd3;
    wr_en_i = 1'b1; wr_reg_i = 2'd1; wr_idx_i = 6'd5; wr_data_i = 16'hBEEF;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; wr_en_i = 1'b0;
    wait_idle();
    check("R8 vl kept", 64'(vl_o), 64'd64);
    check_regs("R8 busy write dropped");

    // R3 R7: length 7 compare
    send(OP_SETVL, 7, 16'h0, 0, 0, 0, "R2");
    send(OP_CMPNE, 0, m_vrf[0][6], 0, 0, 0, "R3");
    wait_idle();
    check("R7 mask len7", mask_o, m_mask);

    repeat (3) @(negedge clk_i);
    check("R10 all done seen", 64'(exp_q.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=end");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule